// File: doc/BRIEF.md
# Clipped Hardware Cursor Overlay

This block lays a small ARGB cursor image over a stream of background pixels. Each beat arrives with its coordinate inside the active area. The block decides whether that coordinate falls inside the visible part of the cursor. If it does, the block reads the matching cursor word from an internal RAM and blends it over the background using the word's alpha.

Cursor geometry is supplied as a signed screen position and a width and height. When `cfg_load` is pulsed, the block clips the rectangle against all four edges of the active area. It then works out where the visible part starts inside the bitmap. The result is held in a staging copy and moves to the working copy only on a frame-done pulse, so the cursor never tears in the middle of a frame. In interlaced operation the vertical position and height are halved, because each field carries half the lines.

The bitmap is written one word at a time through a simple write port. The loader addresses the bitmap row by row, using the full cursor width as the row stride. The pixel stream uses valid/ready handshakes on both sides. A beat is taken when `in_valid` and `in_ready` are both high, and it leaves when `out_valid` and `out_ready` are both high. `in_ready` falls only while a finished pixel waits on a low `out_ready`. During that wait the output beat holds still.

Top module: `cursor_overlay`

## Requirements
- R1: A size is accepted only if width and height are each between 1 and 64 and not both above 32. A load with any other size hides the cursor from the next cycle, and every pixel passes through unchanged.
- R2: A negative X position gives a bitmap column offset equal to its magnitude, a screen X of 0 and a visible width reduced by that magnitude. Negative Y is handled the same way with rows and height.
- R3: If the rectangle runs past the right or bottom edge of the active area, the visible width or height becomes the active size minus the position, with a floor of 0. Pixels beyond that limit pass through unchanged.
- R4: A load whose visible width or height is 0, or a load made while `bitmap_ok` is low, hides the cursor in the cycle after the load, without waiting for frame-done.
- R5: With `interlaced` high, the clipped visible height and the screen Y are both shifted right by one.
- R6: A load with a visible result is staged and raises a pending state. The staged geometry becomes active on the next `frame_done` in a cycle with no `cfg_load`, and the pending state then clears. If `cfg_load` and `frame_done` arrive together, the load is staged and nothing is applied.
- R7: A visible load whose clipped size differs from the active clipped size hides the cursor until that load is applied. A load with the same size keeps the old cursor shown until frame-done.
- R8: Written words are in ARGB order: A in [31:24], R in [23:16], G in [15:8], B in [7:0]. Stream pixels are in [23:16]=B, [15:8]=G, [7:0]=R. The RAM swaps R and B on store, so each colour reaches its own output lane.
- R9: Inside the visible rectangle, each channel of the output is (cursor*alpha + background*(255-alpha))/255, truncated. Outside it the background passes through unchanged.
- R10: Each accepted beat leaves after two pipeline advances, in order. `in_ready` is low exactly while `out_valid` is high and `out_ready` is low, and during such a stall `out_pix` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Pulse: clip and stage the geometry inputs |
| cfg_x | input | CW | Signed cursor X on screen |
| cfg_y | input | CW | Signed cursor Y on screen |
| cfg_w | input | DW | Cursor width in pixels |
| cfg_h | input | DW | Cursor height in pixels |
| bitmap_ok | input | 1 | A cursor bitmap is present |
| interlaced | input | 1 | Field-based output; halve vertical geometry |
| act_w | input | CW | Active area width |
| act_h | input | CW | Active area height |
| frame_done | input | 1 | Pulse at the frame boundary |
| bm_wr_en | input | 1 | Bitmap RAM write strobe |
| bm_wr_addr | input | AW | Bitmap RAM word address (row*width+column) |
| bm_wr_data | input | 32 | ARGB word to store |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_x | input | CW | Beat column in the active area |
| in_y | input | CW | Beat line in the active area (field line when interlaced) |
| in_pix | input | 24 | Background pixel, B/G/R lanes |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_pix | output | 24 | Blended pixel, B/G/R lanes |

## Verification
The bench builds the block with its default parameters: 12-bit coordinates, 7-bit sizes and a 2048-word RAM that holds a full 64x32 bitmap. The active area is driven to 100x80 through the ports. This keeps every edge within reach of short directed runs: negative offsets, the right and bottom clip, clipping down to a zero floor, and the largest accepted 64x32 shape read at its last word. The 7-bit size ports also make rejected sizes such as 65 and 40x40 reachable.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

  localparam int unsigned CH_W = 8;
  localparam int unsigned PIX_W = 3 * CH_W;

  // One colour channel: (c*a + b*(255-a)) / 255, truncated.
  function automatic logic [CH_W-1:0] mix_ch(input logic [CH_W-1:0] c,
                                             input logic [CH_W-1:0] b,
                                             input logic [CH_W-1:0] a);
    logic [2*CH_W-1:0] acc;
    acc = c * a + b * (8'd255 - a);
    return CH_W'(acc / 16'd255);
  endfunction

  // Swap the outer bytes of the colour part of an ARGB word.
  function automatic logic [31:0] argb_to_abgr(input logic [31:0] w);
    return {w[31:24], w[7:0], w[15:8], w[23:16]};
  endfunction

endpackage

// File: rtl/cursor_clip.sv
module cursor_clip #(
  parameter int unsigned CW      = 12,
  parameter int unsigned DW      = 7,
  parameter int unsigned MAX_DIM = 64
) (
  input  logic signed [CW-1:0] pos_x,
  input  logic signed [CW-1:0] pos_y,
  input  logic [DW-1:0]        size_w,
  input  logic [DW-1:0]        size_h,
  input  logic [CW-1:0]        lim_w,
  input  logic [CW-1:0]        lim_h,
  input  logic                 have_bm,
  input  logic                 ilace,
  output logic [CW-1:0]        scr_x,
  output logic [CW-1:0]        scr_y,
  output logic [DW-1:0]        vis_w,
  output logic [DW-1:0]        vis_h,
  output logic [DW-1:0]        off_x,
  output logic [DW-1:0]        off_y,
  output logic                 visible
);
  localparam int unsigned SW   = CW + 2;
  localparam int unsigned HALF = MAX_DIM / 2;
  localparam int unsigned RW   = CW + 2 * DW;

  function automatic logic [RW-1:0] clip_axis(input logic signed [CW-1:0] p,
                                              input logic [DW-1:0] s,
                                              input logic [CW-1:0] lim);
    logic signed [SW-1:0] ps, ss, ls, len;
    logic [CW-1:0] scr;
    logic [DW-1:0] off;
    ps = {{2{p[CW-1]}}, p};
    ss = {{(SW-DW){1'b0}}, s};
    ls = {2'b00, lim};
    if (ps < 0) begin
      off = DW'(-ps);
      scr = '0;
      len = ss + ps;
    end else if (ps + ss > ls) begin
      off = '0;
      scr = p;
      len = ls - ps;
    end else begin
      off = '0;
      scr = p;
      len = ss;
    end
    if (len < 0) len = '0;
    return {scr, DW'(len), off};
  endfunction

  logic [CW-1:0] sy_raw;
  logic [DW-1:0] vh_raw;
  logic          size_ok;

  always_comb begin
    {scr_x, vis_w, off_x}   = clip_axis(pos_x, size_w, lim_w);
    {sy_raw, vh_raw, off_y} = clip_axis(pos_y, size_h, lim_h);
    scr_y = ilace ? (sy_raw >> 1) : sy_raw;
    vis_h = ilace ? (vh_raw >> 1) : vh_raw;
    size_ok = (size_w != '0) && (size_h != '0) &&
              (size_w <= DW'(MAX_DIM)) && (size_h <= DW'(MAX_DIM)) &&
              !((size_w > DW'(HALF)) && (size_h > DW'(HALF)));
    visible = size_ok && have_bm && (vis_w != '0) && (vis_h != '0);
  end

  always_comb begin
    if (visible) begin
      AST_VIS_WITHIN_SIZE: assert (vis_w <= size_w && vis_h <= size_h); // R3
    end
  end

endmodule

// File: rtl/cursor_shadow.sv
module cursor_shadow #(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fdone,
  input  logic          n_vis,
  input  logic [CW-1:0] n_sx,
  input  logic [CW-1:0] n_sy,
  input  logic [DW-1:0] n_vw,
  input  logic [DW-1:0] n_vh,
  input  logic [DW-1:0] n_ox,
  input  logic [DW-1:0] n_oy,
  input  logic [DW-1:0] n_stride,
  output logic [CW-1:0] a_sx,
  output logic [CW-1:0] a_sy,
  output logic [DW-1:0] a_vw,
  output logic [DW-1:0] a_vh,
  output logic [DW-1:0] a_ox,
  output logic [DW-1:0] a_oy,
  output logic [DW-1:0] a_stride,
  output logic          shown,
  output logic          pending
);
  logic [CW-1:0] s_sx, s_sy;
  logic [DW-1:0] s_vw, s_vh, s_ox, s_oy, s_stride;
  logic          resize;

  assign resize = (n_vw != a_vw) || (n_vh != a_vh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_sx, s_sy, s_vw, s_vh, s_ox, s_oy, s_stride} <= '0;
      {a_sx, a_sy, a_vw, a_vh, a_ox, a_oy, a_stride} <= '0;
      shown   <= 1'b0;
      pending <= 1'b0;
    end else if (load) begin
      if (n_vis) begin
        {s_sx, s_sy, s_vw, s_vh, s_ox, s_oy, s_stride} <=
          {n_sx, n_sy, n_vw, n_vh, n_ox, n_oy, n_stride};
        pending <= 1'b1;
        if (resize) shown <= 1'b0;
      end else begin
        pending <= 1'b0;
        shown   <= 1'b0;
      end
    end else if (fdone && pending) begin
      {a_sx, a_sy, a_vw, a_vh, a_ox, a_oy, a_stride} <=
        {s_sx, s_sy, s_vw, s_vh, s_ox, s_oy, s_stride};
      shown   <= 1'b1;
      pending <= 1'b0;
    end
  end

  AST_HIDE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load && !n_vis |=> !shown && !pending); // R4
  AST_RESIZE_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    load && n_vis && resize |=> !shown); // R7
  AST_APPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !load && fdone && pending |=> shown && !pending); // R6
  AST_NO_EARLY_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !fdone |=> $stable(shown)); // R6

endmodule

// File: rtl/cursor_ram.sv
module cursor_ram #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  import cursor_ovl_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= argb_to_abgr(wdata);
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int unsigned CW      = 12,
  parameter int unsigned MAX_DIM = 64,
  parameter int unsigned DW      = $clog2(MAX_DIM + 1),
  parameter int unsigned AW      = $clog2(MAX_DIM * MAX_DIM / 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic signed [CW-1:0] cfg_x,
  input  logic signed [CW-1:0] cfg_y,
  input  logic [DW-1:0]        cfg_w,
  input  logic [DW-1:0]        cfg_h,
  input  logic                 bitmap_ok,
  input  logic                 interlaced,
  input  logic [CW-1:0]        act_w,
  input  logic [CW-1:0]        act_h,
  input  logic                 frame_done,
  input  logic                 bm_wr_en,
  input  logic [AW-1:0]        bm_wr_addr,
  input  logic [31:0]          bm_wr_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CW-1:0]        in_x,
  input  logic [CW-1:0]        in_y,
  input  logic [23:0]          in_pix,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [23:0]          out_pix
);
  import cursor_ovl_pkg::*;

  logic [CW-1:0] n_sx, n_sy, a_sx, a_sy;
  logic [DW-1:0] n_vw, n_vh, n_ox, n_oy;
  logic [DW-1:0] a_vw, a_vh, a_ox, a_oy, a_stride;
  logic          n_vis, shown, pending;

  cursor_clip #(.CW(CW), .DW(DW), .MAX_DIM(MAX_DIM)) u_clip (
    .pos_x(cfg_x), .pos_y(cfg_y), .size_w(cfg_w), .size_h(cfg_h),
    .lim_w(act_w), .lim_h(act_h), .have_bm(bitmap_ok), .ilace(interlaced),
    .scr_x(n_sx), .scr_y(n_sy), .vis_w(n_vw), .vis_h(n_vh),
    .off_x(n_ox), .off_y(n_oy), .visible(n_vis)
  );

  cursor_shadow #(.CW(CW), .DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .fdone(frame_done),
    .n_vis(n_vis), .n_sx(n_sx), .n_sy(n_sy), .n_vw(n_vw), .n_vh(n_vh),
    .n_ox(n_ox), .n_oy(n_oy), .n_stride(cfg_w),
    .a_sx(a_sx), .a_sy(a_sy), .a_vw(a_vw), .a_vh(a_vh),
    .a_ox(a_ox), .a_oy(a_oy), .a_stride(a_stride),
    .shown(shown), .pending(pending)
  );

  // Stage 0: hit test and RAM address.
  logic          advance;
  logic [CW:0]   dx, dy;
  logic          hit;
  logic [DW:0]   row, col;
  logic [AW-1:0] raddr;

  assign advance  = !(out_valid && !out_ready);
  assign in_ready = advance;

  always_comb begin
    dx  = {1'b0, in_x} - {1'b0, a_sx};
    dy  = {1'b0, in_y} - {1'b0, a_sy};
    hit = shown && !dx[CW] && !dy[CW] &&
          (dx[CW-1:0] < CW'(a_vw)) && (dy[CW-1:0] < CW'(a_vh));
    row   = {1'b0, a_oy} + {1'b0, dy[DW-1:0]};
    col   = {1'b0, a_ox} + {1'b0, dx[DW-1:0]};
    raddr = AW'(row * a_stride + col);
  end

  // Stage 1: RAM word arrives alongside the registered beat.
  logic [31:0] cur_word;
  logic        s1_v, s1_hit;
  logic [23:0] s1_bg;

  cursor_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(bm_wr_en), .waddr(bm_wr_addr), .wdata(bm_wr_data),
    .re(advance), .raddr(raddr), .rdata(cur_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_hit <= 1'b0;
      s1_bg  <= '0;
    end else if (advance) begin
      s1_v   <= in_valid;
      s1_hit <= hit;
      s1_bg  <= in_pix;
    end
  end

  // Stage 2: blend into the output register.
  logic [23:0] mixed;
  always_comb begin
    if (s1_hit) begin
      for (int k = 0; k < 3; k++)
        mixed[8*k +: 8] = mix_ch(cur_word[8*k +: 8], s1_bg[8*k +: 8], cur_word[31:24]);
    end else begin
      mixed = s1_bg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (advance) begin
      out_valid <= s1_v;
      out_pix   <= mixed;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R10
  AST_NO_ACCEPT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10

endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  localparam int CW = 12;
  localparam int DW = 7;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 0, bitmap_ok = 0, interlaced = 0, frame_done = 0;
  logic signed [CW-1:0] cfg_x = '0, cfg_y = '0;
  logic [DW-1:0] cfg_w = '0, cfg_h = '0;
  logic [CW-1:0] act_w = 12'd100, act_h = 12'd80;
  logic bm_wr_en = 0;
  logic [AW-1:0] bm_wr_addr = '0;
  logic [31:0] bm_wr_data = '0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [CW-1:0] in_x = '0, in_y = '0;
  logic [23:0] in_pix = '0, out_pix;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_x(cfg_x), .cfg_y(cfg_y),
    .cfg_w(cfg_w), .cfg_h(cfg_h), .bitmap_ok(bitmap_ok), .interlaced(interlaced),
    .act_w(act_w), .act_h(act_h), .frame_done(frame_done), .bm_wr_en(bm_wr_en),
    .bm_wr_addr(bm_wr_addr), .bm_wr_data(bm_wr_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  localparam logic [23:0] BG = 24'h5A_A5_3C;

  // Bitmap pattern in ARGB; expected stream lanes are {B,G,R}.
  function automatic logic [31:0] pat(int r, int c);
    return {8'hFF, 8'(r * 4 + 1), 8'(c * 4 + 2), 8'h33};
  endfunction
  function automatic logic [23:0] ex(int r, int c);
    return {8'h33, 8'(c * 4 + 2), 8'(r * 4 + 1)};
  endfunction
  function automatic logic [7:0] mixm(logic [7:0] c, logic [7:0] b, logic [7:0] a);
    int t;
    t = (int'(c) * int'(a) + int'(b) * (255 - int'(a))) / 255;
    return 8'(t);
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic load_bitmap(int w, int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        bm_wr_en = 1; bm_wr_addr = AW'(r * w + c); bm_wr_data = pat(r, c);
      end
    @(negedge clk);
    bm_wr_en = 0;
  endtask

  task automatic write_word(int a, logic [31:0] d);
    @(negedge clk);
    bm_wr_en = 1; bm_wr_addr = AW'(a); bm_wr_data = d;
    @(negedge clk);
    bm_wr_en = 0;
  endtask

  task automatic cfg(int x, int y, int w, int h, bit bm, bit il, bit with_fd);
    @(negedge clk);
    cfg_x = CW'(x); cfg_y = CW'(y); cfg_w = DW'(w); cfg_h = DW'(h);
    bitmap_ok = bm; interlaced = il; cfg_load = 1; frame_done = with_fd;
    @(negedge clk);
    cfg_load = 0; frame_done = 0;
  endtask

  task automatic fdone();
    @(negedge clk);
    frame_done = 1;
    @(negedge clk);
    frame_done = 0;
  endtask

  task automatic pixel(int x, int y, logic [23:0] bg, output logic [23:0] res);
    @(negedge clk);
    in_valid = 1; in_x = CW'(x); in_y = CW'(y); in_pix = bg;
    @(negedge clk);
    in_valid = 0;
    res = 24'hxxxxxx;
    for (int k = 0; k < 6; k++) begin
      if (out_valid) begin
        res = out_pix;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 reset out_valid", {23'd0, out_valid}, 24'd0);
    check("R10 reset in_ready", {23'd0, in_ready}, 24'd1);
  endtask

  task automatic t_no_bitmap();
    logic [23:0] p;
    load_bitmap(8, 4);
    cfg(10, 5, 8, 4, 0, 0, 0);
    fdone();
    pixel(10, 5, BG, p);
    check("R4 no bitmap passes background", p, BG);
  endtask

  task automatic t_basic();
    logic [23:0] p;
    cfg(10, 5, 8, 4, 1, 0, 0);
    pixel(10, 5, BG, p);
    check("R6 staged not yet applied", p, BG);
    fdone();
    pixel(10, 5, BG, p);
    check("R8 top-left word with lanes swapped", p, ex(0, 0));
    pixel(17, 8, BG, p);
    check("R9 bottom-right inside", p, ex(3, 7));
    pixel(18, 5, BG, p);
    check("R9 right of cursor passes", p, BG);
    pixel(10, 9, BG, p);
    check("R9 below cursor passes", p, BG);
  endtask

  task automatic t_move_same_size();
    logic [23:0] p;
    cfg(20, 5, 8, 4, 1, 0, 0);
    pixel(10, 5, BG, p);
    check("R7 same size keeps old cursor", p, ex(0, 0));
    pixel(20, 5, BG, p);
    check("R6 new position waits", p, BG);
    cfg(30, 5, 8, 4, 1, 0, 1);
    pixel(30, 5, BG, p);
    check("R6 load with frame_done not applied", p, BG);
    fdone();
    pixel(30, 5, BG, p);
    check("R6 applied on later frame_done", p, ex(0, 0));
    pixel(20, 5, BG, p);
    check("R6 intermediate position never applied", p, BG);
  endtask

  task automatic t_negative();
    logic [23:0] p;
    cfg(-3, -2, 8, 4, 1, 0, 0);
    pixel(30, 5, BG, p);
    check("R7 resize hides before apply", p, BG);
    fdone();
    pixel(0, 0, BG, p);
    check("R2 negative offset origin", p, ex(2, 3));
    pixel(4, 1, BG, p);
    check("R2 last visible word", p, ex(3, 7));
    pixel(5, 0, BG, p);
    check("R2 width reduced", p, BG);
    pixel(0, 2, BG, p);
    check("R2 height reduced", p, BG);
  endtask

  task automatic t_right_bottom();
    logic [23:0] p;
    cfg(96, 78, 8, 4, 1, 0, 1'b0);
    fdone();
    pixel(99, 79, BG, p);
    check("R3 clipped corner", p, ex(1, 3));
    pixel(100, 78, BG, p);
    check("R3 beyond right edge passes", p, BG);
    cfg(120, 10, 8, 4, 1, 0, 0);
    pixel(99, 79, BG, p);
    check("R3 floor zero hides cursor", p, BG);
  endtask

  task automatic t_interlace();
    logic [23:0] p;
    cfg(10, 6, 8, 4, 1, 1, 0);
    fdone();
    pixel(10, 3, BG, p);
    check("R5 halved screen y", p, ex(0, 0));
    pixel(10, 4, BG, p);
    check("R5 second field line", p, ex(1, 0));
    pixel(10, 5, BG, p);
    check("R5 halved height", p, BG);
  endtask

  task automatic t_blend();
    logic [23:0] p, bg2;
    logic [31:0] w;
    cfg(10, 5, 8, 4, 1, 0, 0);
    fdone();
    w = {8'h80, 8'hC8, 8'h10, 8'h40};
    bg2 = {8'h00, 8'hFF, 8'h20};
    write_word(0, w);
    pixel(10, 5, bg2, p);
    check("R9 half alpha blend", p,
          {mixm(8'h40, 8'h00, 8'h80), mixm(8'h10, 8'hFF, 8'h80), mixm(8'hC8, 8'h20, 8'h80)});
    write_word(1, {8'h00, 8'hC8, 8'h10, 8'h40});
    pixel(11, 5, bg2, p);
    check("R9 zero alpha keeps background", p, bg2);
  endtask

  task automatic t_stall();
    logic [23:0] a;
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_x = 12'd10; in_y = 12'd6; in_pix = BG;
    @(negedge clk);
    in_x = 12'd11;
    @(negedge clk);
    in_valid = 0;
    check("R10 ready low while stalled", {23'd0, in_ready}, 24'd0);
    check("R10 first beat at output", out_pix, ex(1, 0));
    a = out_pix;
    repeat (3) @(negedge clk);
    check("R10 output held in stall", out_pix, a);
    out_ready = 1;
    @(negedge clk);
    check("R10 second beat in order", {out_valid ? out_pix : 24'hxxxxxx}, ex(1, 1));
    @(negedge clk);
    check("R10 pipeline drained", {23'd0, out_valid}, 24'd0);
  endtask

  task automatic t_limits();
    logic [23:0] p;
    cfg(10, 5, 40, 40, 1, 0, 0);
    pixel(10, 6, BG, p);
    check("R1 40x40 rejected at once", p, BG);
    load_bitmap(64, 32);
    cfg(0, 0, 64, 32, 1, 0, 0);
    fdone();
    pixel(63, 31, BG, p);
    check("R1 64x32 last word", p, ex(31, 63));
    cfg(0, 0, 65, 8, 1, 0, 0);
    pixel(0, 0, BG, p);
    check("R1 width 65 rejected", p, BG);
    cfg(0, 0, 64, 32, 1, 0, 0);
    fdone();
    cfg(0, 0, 0, 8, 1, 0, 0);
    pixel(1, 1, BG, p);
    check("R1 zero width rejected", p, BG);
    cfg(0, 0, 64, 32, 1, 0, 0);
    fdone();
    pixel(2, 1, BG, p);
    check("R1 restored cursor shown", p, ex(1, 2));
    cfg(0, 0, 64, 32, 0, 0, 0);
    pixel(2, 1, BG, p);
    check("R4 bitmap drop hides at once", p, BG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_no_bitmap();
    t_basic();
    t_move_same_size();
    t_negative();
    t_right_bottom();
    t_interlace();
    t_blend();
    t_stall();
    t_limits();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule